// File: doc/BRIEF.md
# Page-Mode NOR Read Controller

This block sits on the host side of an asynchronous parallel NOR memory. It turns single read requests into pin activity on the memory: chip enable, output enable, the word address and a byte-lane select. It waits a set number of clocks, captures the data bus and hands the result back with a one-cycle strobe. Requests arrive on a valid/ready handshake as a word address, a byte-mode flag and a byte-select bit. The memory generates no addresses of its own, so every access carries its full address.

The memory can return data faster when a read stays inside the page that was just opened. A page holds eight words, or sixteen bytes in byte mode. The controller remembers which page is open and whether chip enable has stayed low since that page was opened. A request that hits the open page waits only the short page latency. Any other request waits the full random-access latency. After a run of idle clocks the controller releases chip enable and forgets the open page.

Top module: `nor_page_reader`

## Requirements
- R1: `reqReady` is high exactly when no read is in progress. A request is accepted on a clock edge where `reqValid` and `reqReady` are both high.
- R2: The first read after reset waits `FULL_LAT` clocks. So does any read whose page tag `reqAddr[ADDR_W-1:3]` differs from the open page, and any read issued while chip enable is released. Data is captured on the edge that is `FULL_LAT` edges after the accepting edge, and `rspValid` is high in the following cycle.
- R3: A read whose page tag equals the open page, issued while chip enable is still held low, waits `PAGE_LAT` clocks instead. Address bits [2:0], `reqByteSel` and `reqByteMode` play no part in the page match.
- R4: Suppose `IDLE_LIM` consecutive cycles pass with `reqReady` high and no request. Chip enable is then deasserted (`memCeN` = 1) from the next cycle onward, and the next read takes the full latency. A request in the cycle before that point still counts as a page hit.
- R5: `memWeN` is always 1. `memOeN` is 0 only while a read is waiting. `memCeN` is 0 whenever `memOeN` is 0.
- R6: From the cycle after acceptance until the data is captured, `memAddr` equals the accepted `reqAddr` and does not change. Over the same span `memLsb` and `memByteN` do not change either.
- R7: In word mode (`reqByteMode` = 0), `memByteN` is 1 and `rspData` equals the 16-bit data bus. In byte mode (`reqByteMode` = 1), `memByteN` is 0 and `memLsb` equals `reqByteSel`. In that mode `rspData` is `{8'h00, memData[7:0]}`.
- R8: `rspValid` is a single-cycle pulse, one per accepted request, in request order.
- R9: After reset, `reqReady` = 1, `rspValid` = 0, and `memCeN`, `memOeN` and `memWeN` are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Read request present |
| reqReady | output | 1 | Controller can take a request |
| reqAddr | input | ADDR_W | Word address of the read |
| reqByteMode | input | 1 | 1 = byte-wide read, 0 = word read |
| reqByteSel | input | 1 | Byte within the word in byte mode (1 = upper byte) |
| rspValid | output | 1 | One-cycle strobe with returned data |
| rspData | output | DATA_W | Returned data |
| memCeN | output | 1 | Memory chip enable, active low |
| memOeN | output | 1 | Memory output enable, active low |
| memWeN | output | 1 | Memory write enable, active low, held high |
| memByteN | output | 1 | Memory bus width select, low for byte mode |
| memAddr | output | ADDR_W | Memory word address |
| memLsb | output | 1 | Lowest byte address bit in byte mode |
| memData | input | DATA_W | Memory data bus |

## Verification
Some rules can be judged from one cycle, or a short window, of the ports. The assertions check these on every cycle. Write enable must stay high. Output enable may only be low while chip enable is low. The address pins must hold still through a wait. The response strobe must stay one cycle wide. Every wait must last one of the two configured lengths. Chip enable must be released once the idle run reaches its limit. The assertions cannot tell which of the two latencies a given read should have had. The bench's scenarios settle that with a model of the open page. These scenarios cover an idle gap one cycle short of the release limit and a gap exactly at it, along with in-page word and byte reads.

// File: rtl/nor_rd_pkg.sv
package nor_rd_pkg;

  // Strobes from the control FSM to the datapath registers
  typedef struct packed {
    logic loadAddr;   // latch request address, mode and page tag
    logic capture;    // sample the memory data bus
  } ctlStrobe_t;

  localparam int unsigned PAGE_BITS = 3;  // eight words per page

endpackage

// File: rtl/nor_rd_datapath.sv
module nor_rd_datapath
  import nor_rd_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqByteMode,
  input  logic              reqByteSel,
  input  logic [DATA_W-1:0] memData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memLsb,
  output logic              memByteN,
  output logic              tagMatch,
  output logic [DATA_W-1:0] rspData
);

  localparam int unsigned TAG_W  = ADDR_W - PAGE_BITS;
  localparam int unsigned HALF_W = DATA_W / 2;

  logic [ADDR_W-1:0] addrReg;
  logic [TAG_W-1:0]  openTag;
  logic              byteModeReg;
  logic              byteSelReg;
  logic [DATA_W-1:0] dataReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg     <= '0;
      openTag     <= '0;
      byteModeReg <= 1'b0;
      byteSelReg  <= 1'b0;
    end else if (strobe.loadAddr) begin
      addrReg     <= reqAddr;
      openTag     <= reqAddr[ADDR_W-1:PAGE_BITS];
      byteModeReg <= reqByteMode;
      byteSelReg  <= reqByteSel;
    end
  end

  // Byte reads use only the low lane of the bus; the upper lane is cleared
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg <= '0;
    end else if (strobe.capture) begin
      if (byteModeReg) begin
        dataReg <= {{(DATA_W-HALF_W){1'b0}}, memData[HALF_W-1:0]};
      end else begin
        dataReg <= memData;
      end
    end
  end

  assign tagMatch = (reqAddr[ADDR_W-1:PAGE_BITS] == openTag);
  assign memAddr  = addrReg;
  assign memLsb   = byteModeReg & byteSelReg;
  assign memByteN = ~byteModeReg;
  assign rspData  = dataReg;

endmodule

// File: rtl/nor_rd_control.sv
module nor_rd_control
  import nor_rd_pkg::*;
#(
  parameter int unsigned FULL_LAT = 6,
  parameter int unsigned PAGE_LAT = 2,
  parameter int unsigned IDLE_LIM = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       tagMatch,
  output logic       reqReady,
  output ctlStrobe_t strobe,
  output logic       memCeN,
  output logic       memOeN,
  output logic       rspValid
);

  localparam int unsigned LAT_W  = $clog2(FULL_LAT + 1);
  localparam int unsigned IDLE_W = $clog2(IDLE_LIM + 1);

  typedef enum logic {StIdle, StWait} ctlState_t;

  ctlState_t         state;
  logic [LAT_W-1:0]  waitCnt;
  logic [IDLE_W-1:0] idleCnt;
  logic              ceOn;
  logic              pageValid;
  logic              accept;
  logic              pageHit;
  logic              lastWait;

  assign accept   = reqValid && (state == StIdle);
  assign pageHit  = pageValid && ceOn && tagMatch;
  assign lastWait = (state == StWait) && (waitCnt == LAT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= StIdle;
      waitCnt   <= '0;
      idleCnt   <= '0;
      ceOn      <= 1'b0;
      pageValid <= 1'b0;
      rspValid  <= 1'b0;
    end else begin
      rspValid <= 1'b0;
      case (state)
        StIdle: begin
          if (accept) begin
            state     <= StWait;
            waitCnt   <= pageHit ? LAT_W'(PAGE_LAT) : LAT_W'(FULL_LAT);
            ceOn      <= 1'b1;
            pageValid <= 1'b1;
            idleCnt   <= '0;
          end else if (ceOn) begin
            if (idleCnt == IDLE_W'(IDLE_LIM - 1)) begin
              ceOn      <= 1'b0;
              pageValid <= 1'b0;
              idleCnt   <= '0;
            end else begin
              idleCnt <= idleCnt + 1'b1;
            end
          end
        end
        StWait: begin
          if (lastWait) begin
            state    <= StIdle;
            rspValid <= 1'b1;
          end else begin
            waitCnt <= waitCnt - 1'b1;
          end
        end
        default: state <= StIdle;
      endcase
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.loadAddr = accept;
    strobe.capture  = lastWait;
  end

  assign reqReady = (state == StIdle);
  assign memCeN   = ~ceOn;
  assign memOeN   = (state != StWait);

endmodule

// File: rtl/nor_page_reader.sv
module nor_page_reader
  import nor_rd_pkg::*;
#(
  parameter int unsigned ADDR_W   = 20,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned FULL_LAT = 6,
  parameter int unsigned PAGE_LAT = 2,
  parameter int unsigned IDLE_LIM = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqByteMode,
  input  logic              reqByteSel,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              memCeN,
  output logic              memOeN,
  output logic              memWeN,
  output logic              memByteN,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memLsb,
  input  logic [DATA_W-1:0] memData
);

  ctlStrobe_t strobe;
  logic       tagMatch;

  nor_rd_control #(
    .FULL_LAT(FULL_LAT),
    .PAGE_LAT(PAGE_LAT),
    .IDLE_LIM(IDLE_LIM)
  ) u_control (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .tagMatch (tagMatch),
    .reqReady (reqReady),
    .strobe   (strobe),
    .memCeN   (memCeN),
    .memOeN   (memOeN),
    .rspValid (rspValid)
  );

  nor_rd_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .reqAddr     (reqAddr),
    .reqByteMode (reqByteMode),
    .reqByteSel  (reqByteSel),
    .memData     (memData),
    .memAddr     (memAddr),
    .memLsb      (memLsb),
    .memByteN    (memByteN),
    .tagMatch    (tagMatch),
    .rspData     (rspData)
  );

  assign memWeN = 1'b1;

endmodule

// File: rtl/nor_page_reader_chk.sv
module nor_page_reader_chk #(
  parameter int unsigned ADDR_W   = 20,
  parameter int unsigned FULL_LAT = 6,
  parameter int unsigned PAGE_LAT = 2,
  parameter int unsigned IDLE_LIM = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              rspValid,
  input logic              memCeN,
  input logic              memOeN,
  input logic              memWeN,
  input logic              memByteN,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memLsb
);

  logic [15:0] idleRun;
  logic [15:0] busyRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idleRun <= '0;
      busyRun <= '0;
    end else begin
      if (reqReady && !reqValid) begin
        if (idleRun != 16'(IDLE_LIM)) idleRun <= idleRun + 1'b1;
      end else begin
        idleRun <= '0;
      end
      if (reqValid && reqReady) busyRun <= '0;
      else if (!reqReady) busyRun <= busyRun + 1'b1;
    end
  end

  // R5: write enable never asserted
  assert_we_high_R5: assert property (@(posedge clk) disable iff (!rstN)
    memWeN);

  // R5: output enable only under chip enable
  assert_oe_under_ce_R5: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> !memCeN);

  // R1 / R5: output enable released whenever the controller is free
  assert_ready_oe_off_R1: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> memOeN);

  // R6: accepted address reaches the pins
  assert_addr_loaded_R6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (memAddr == $past(reqAddr)));

  // R6: pins hold still through a wait
  assert_pins_stable_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!reqReady && $past(!reqReady)) |->
      ($stable(memAddr) && $stable(memLsb) && $stable(memByteN)));

  // R8: response strobe is one cycle wide
  assert_rsp_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  // R2 / R3: every wait has one of the two configured lengths
  assert_wait_len_R2: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (busyRun == 16'(FULL_LAT) || busyRun == 16'(PAGE_LAT)));

  // R4: chip enable released after the idle limit
  assert_idle_release_R4: assert property (@(posedge clk) disable iff (!rstN)
    (idleRun == 16'(IDLE_LIM)) |-> memCeN);

endmodule

bind nor_page_reader nor_page_reader_chk #(
  .ADDR_W  (ADDR_W),
  .FULL_LAT(FULL_LAT),
  .PAGE_LAT(PAGE_LAT),
  .IDLE_LIM(IDLE_LIM)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .reqAddr  (reqAddr),
  .rspValid (rspValid),
  .memCeN   (memCeN),
  .memOeN   (memOeN),
  .memWeN   (memWeN),
  .memByteN (memByteN),
  .memAddr  (memAddr),
  .memLsb   (memLsb)
);

// File: tb/test_nor_page_reader.sv
`timescale 1ns/1ps
module test_nor_page_reader;

  localparam int unsigned ADDR_W   = 20;
  localparam int unsigned DATA_W   = 16;
  localparam int unsigned FULL_LAT = 6;
  localparam int unsigned PAGE_LAT = 2;
  localparam int unsigned IDLE_LIM = 8;

  typedef struct {
    logic [DATA_W-1:0] data;
    int unsigned       lat;
    longint            acceptCyc;
    string             tag;
  } expItem_t;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic              reqReady;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic              reqByteMode = 1'b0;
  logic              reqByteSel = 1'b0;
  logic              rspValid;
  logic [DATA_W-1:0] rspData;
  logic              memCeN, memOeN, memWeN, memByteN, memLsb;
  logic [ADDR_W-1:0] memAddr;
  logic [DATA_W-1:0] memData;

  int     checks = 0;
  int     fails = 0;
  longint cyc = 0;
  expItem_t expQ[$];

  // bench model of the open page
  logic              mdlOpen = 1'b0;
  logic [ADDR_W-4:0] mdlTag = '0;
  longint            mdlLastCap = 0;

  always #10 clk = ~clk;  // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  nor_page_reader #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .FULL_LAT(FULL_LAT), .PAGE_LAT(PAGE_LAT), .IDLE_LIM(IDLE_LIM)
  ) i_nor_page_reader (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
    .reqByteMode(reqByteMode), .reqByteSel(reqByteSel),
    .rspValid(rspValid), .rspData(rspData),
    .memCeN(memCeN), .memOeN(memOeN), .memWeN(memWeN),
    .memByteN(memByteN), .memAddr(memAddr), .memLsb(memLsb),
    .memData(memData)
  );

  function automatic logic [15:0] cellWord(logic [ADDR_W-1:0] a);
    logic [31:0] p;
    p = 32'(a) * 32'h0000_9E37;
    return p[15:0] ^ 16'h1234 ^ {a[3:0], 12'h000};
  endfunction

  // memory model: drives the bus only while both enables are low
  always_comb begin
    logic [15:0] w;
    w = cellWord(memAddr);
    if (!memCeN && !memOeN) begin
      memData = memByteN ? w : {8'hFF, (memLsb ? w[15:8] : w[7:0])};
    end else begin
      memData = 16'hDEAD;
    end
  end

  task automatic check(input logic ok, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  // driver: wait gap idle cycles, issue one read, return after its response
  task automatic doRead(input logic [ADDR_W-1:0] a, input logic bm,
                        input logic bs, input int gap, input string tag);
    expItem_t it;
    logic     hit;
    logic [15:0] w;
    repeat (gap) @(negedge clk);
    it.acceptCyc = cyc + 1;
    hit = mdlOpen && (mdlTag == a[ADDR_W-1:3]) &&
          ((it.acceptCyc - mdlLastCap - 1) < IDLE_LIM);
    it.lat = hit ? PAGE_LAT : FULL_LAT;
    w = cellWord(a);
    it.data = bm ? {8'h00, (bs ? w[15:8] : w[7:0])} : w;
    it.tag  = tag;
    expQ.push_back(it);
    mdlOpen    = 1'b1;
    mdlTag     = a[ADDR_W-1:3];
    mdlLastCap = it.acceptCyc + it.lat;
    check(reqReady == 1'b1, "R1 ready before request", reqReady, 1);
    reqValid = 1'b1; reqAddr = a; reqByteMode = bm; reqByteSel = bs;
    @(negedge clk);
    reqValid = 1'b0;
    // R5/R6/R7: pins during the wait
    check(!memOeN && !memCeN, "R5 enables low in wait", {memCeN, memOeN}, 0);
    check(memAddr == a, "R6 address on pins", memAddr, a);
    check(memByteN == !bm, "R7 byte-width pin", memByteN, !bm);
    check(!reqReady, "R1 busy in wait", reqReady, 0);
    while (!rspValid) @(negedge clk);
  endtask

  // monitor: scoreboard compare on every response
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R8 unexpected response", rspData, 0);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        check(rspData == e.data, {e.tag, " data"}, rspData, e.data);
        check((cyc - e.acceptCyc) == longint'(e.lat), {e.tag, " latency"},
              cyc - e.acceptCyc, e.lat);
      end
    end
  end

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check(reqReady == 1'b1, "R9 ready in reset", reqReady, 1);
    check(rspValid == 1'b0, "R9 no response in reset", rspValid, 0);
    check(memCeN && memOeN && memWeN, "R9 pins idle in reset",
          {memCeN, memOeN, memWeN}, 3'b111);
    rstN = 1'b1;
    @(negedge clk);

    doRead(20'h01230, 1'b0, 1'b0, 0, "R2 first read");
    doRead(20'h01235, 1'b0, 1'b0, 0, "R3 in-page word");
    doRead(20'h01237, 1'b1, 1'b1, 0, "R7 byte upper hit R3");
    doRead(20'h01232, 1'b1, 1'b0, 2, "R7 byte lower hit R3");
    doRead(20'h01238, 1'b0, 1'b0, 0, "R2 next page miss");
    doRead(20'h0123F, 1'b0, 1'b0, IDLE_LIM - 1, "R4 gap below limit hit");
    doRead(20'h01239, 1'b0, 1'b0, IDLE_LIM, "R4 gap at limit miss");
    doRead(20'hFFFF8, 1'b0, 1'b0, 0, "R2 far page miss");
    doRead(20'hFFFFF, 1'b1, 1'b1, 0, "R3 top page hit");

    // R4: chip enable released after a long idle run
    repeat (IDLE_LIM + 2) @(negedge clk);
    check(memCeN == 1'b1, "R4 chip enable released", memCeN, 1);
    check(memWeN == 1'b1, "R5 write enable high", memWeN, 1);
    doRead(20'hFFFFE, 1'b0, 1'b0, 0, "R4 same page after release miss");
    doRead(20'hFFFFD, 1'b0, 1'b0, 0, "R3 hit after reopen");

    @(negedge clk);
    check(expQ.size() == 0, "R8 all responses returned", expQ.size(), 0);
    check(rspValid == 1'b0, "R8 pulse ended", rspValid, 0);
    finishRun();
  end

endmodule